// File: doc/BRIEF.md
# Melody Tone Generator

This block plays a melody as a square wave on one non-inverted output pin, clocked from a 32.768 kHz low-speed clock. Software writes a list of note words into program memory and pulses start with the list's base address. The block then reads the words one at a time through a simple read port that returns data one cycle after the request. Each word gives a pitch period, a length code and an end flag. The length code is scaled by a 15-step tempo setting to give the note's duration.

Each next word is read one clock before the current note runs out, so the notes follow one another with no gap. A word with its end flag set stops the sequencer, drives the pin low and pulses an interrupt for one cycle. A stop input aborts the melody at any time. A buzzer enable overrides the pin with a fixed tone at one eighth of the clock rate, which is 4 kHz at 32.768 kHz.

Top module: `melody_tone_gen`

## Requirements
- R1: During reset and after it, until the first start, `tone_o`, `irq_o` and `mem_rd_o` are low.
- R2: A `start_i` pulse seen while idle raises `mem_rd_o` in the next cycle, with `mem_addr_o` equal to `base_addr_i`. Each later read uses the previous read address plus one.
- R3: Note word fields are: bit 12 is the end flag, bits 11:6 are the length code and bits 5:0 are the period P in clocks. A note drives a square wave of period P. The wave is high for the first P - floor(P/2) cycles of each period, and it starts high in the note's first cycle.
- R4: A period below 11 plays as 11, and a period above 62 plays as 62.
- R5: A note lasts L x (16 - T) x 256 cycles. L is the length code and T is the value of `tempo_i` sampled when the note is loaded. L = 0 counts as 1, and T = 0 counts as 1.
- R6: The read for the next word is issued in the second-to-last cycle of the current note. The next note begins in the cycle right after the current note's last cycle, and no two reads occur in consecutive cycles.
- R7: Loading a word with the end flag set drives `tone_o` low from the next cycle, raises `irq_o` for exactly that one cycle, and stops all further reads.
- R8: `stop_i` returns the block to idle at the next edge. From then on, the output is low and there is no interrupt and no read.
- R9: A `start_i` pulse received while a melody is in progress has no effect on addresses or tones.
- R10: While `buzz_en_i` is high, `tone_o` follows a free-running divide-by-8 counter that is cleared by reset and advances every clock. The output is high when the counter is 4 to 7. The sequencer keeps running underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed tone clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| stop_i | input | 1 | Abort pulse |
| buzz_en_i | input | 1 | Fixed buzzer tone override |
| tempo_i | input | 4 | Tempo code, 1 = slowest, 15 = fastest |
| base_addr_i | input | 12 | Address of the first note word |
| mem_rd_o | output | 1 | Read request to program memory |
| mem_addr_o | output | 12 | Read address |
| mem_data_i | input | 13 | Note word, valid the cycle after the request |
| tone_o | output | 1 | Non-inverted tone output |
| irq_o | output | 1 | One-cycle end-of-melody pulse |

## Verification
The bench plays melodies that cross note boundaries at several tempos. A design that read the next word one cycle late would leave a low gap between notes, and one that read it early would cut the note short. Each such error shows up as a tone mismatch at the boundary. The periods used sit at the clamp edges and beyond them, so a missing clamp or an odd-period duty error changes the waveform. Stop during playback, start during playback and a buzzer window laid over a running melody check the following: no stray interrupt, no address jump, and that the sequencer kept its place under the override.

// File: rtl/melody_pkg.sv
package melody_pkg;
  localparam int LEN_W   = 6;
  localparam int PER_W   = 6;
  localparam int TEMPO_W = 4;
  localparam int NOTE_W  = 1 + LEN_W + PER_W;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_PLAY} seq_state_e;

  typedef struct packed {
    logic             fin;
    logic [LEN_W-1:0] len;
    logic [PER_W-1:0] per;
  } note_t;
endpackage

// File: rtl/melody_note_timer.sv
module melody_note_timer #(
  parameter int LEN_W      = 6,
  parameter int TEMPO_W    = 4,
  parameter int TICK_SHIFT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               clr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [TEMPO_W-1:0] tempo_i,
  output logic               near_end_o
);
  localparam int TICK_W = TEMPO_W + TICK_SHIFT;

  logic [TEMPO_W-1:0] tempo_eff, step_n, step_q;
  logic [LEN_W-1:0]   len_eff, len_q;
  logic [TICK_W-1:0]  tick_q;
  logic               run_q;

  function automatic logic [TICK_W-1:0] reload(input logic [TEMPO_W-1:0] s);
    return {s, {TICK_SHIFT{1'b0}}} - TICK_W'(1);
  endfunction

  always_comb begin
    tempo_eff = (tempo_i == '0) ? TEMPO_W'(1) : tempo_i;
    step_n    = TEMPO_W'(0) - tempo_eff;  // 2^TEMPO_W - tempo
    len_eff   = (len_i == '0) ? LEN_W'(1) : len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      step_q <= '0;
      len_q  <= '0;
      tick_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
    end else if (load_i) begin
      run_q  <= 1'b1;
      step_q <= step_n;
      len_q  <= len_eff;
      tick_q <= reload(step_n);
    end else if (run_q) begin
      if (tick_q == '0) begin
        tick_q <= reload(step_q);
        len_q  <= len_q - LEN_W'(1);
        if (len_q == LEN_W'(1)) run_q <= 1'b0;
      end else begin
        tick_q <= tick_q - TICK_W'(1);
      end
    end
  end

  assign near_end_o = run_q && (len_q == LEN_W'(1)) && (tick_q == TICK_W'(1));
endmodule

// File: rtl/melody_pitch_gen.sv
module melody_pitch_gen #(
  parameter int PER_W   = 6,
  parameter int PER_MIN = 11,
  parameter int PER_MAX = 62
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] per_i,
  output logic             wave_o
);
  localparam logic [PER_W-1:0] P_LO = PER_W'(PER_MIN);
  localparam logic [PER_W-1:0] P_HI = PER_W'(PER_MAX);

  logic [PER_W-1:0] per_c, per_q, hi_q, ph_q;

  always_comb begin
    if (per_i < P_LO)      per_c = P_LO;
    else if (per_i > P_HI) per_c = P_HI;
    else                   per_c = per_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= P_LO;
      hi_q  <= '0;
      ph_q  <= '0;
    end else if (load_i) begin
      per_q <= per_c;
      hi_q  <= per_c - (per_c >> 1);
      ph_q  <= '0;
    end else if (run_i) begin
      ph_q <= (ph_q == per_q - PER_W'(1)) ? '0 : ph_q + PER_W'(1);
    end
  end

  assign wave_o = ph_q < hi_q;
endmodule

// File: rtl/melody_buzz_div.sv
module melody_buzz_div #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wave_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + DIV_LOG2'(1);
  end

  assign wave_o = cnt_q[DIV_LOG2-1];
endmodule

// File: rtl/melody_tone_gen.sv
module melody_tone_gen
  import melody_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int TICK_SHIFT = 8,
  parameter int PER_MIN    = 11,
  parameter int PER_MAX    = 62,
  parameter int BUZZ_LOG2  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               buzz_en_i,
  input  logic [TEMPO_W-1:0] tempo_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  output logic               mem_rd_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [NOTE_W-1:0]  mem_data_i,
  output logic               tone_o,
  output logic               irq_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q, irq_q;
  logic              near_end, wave, buzz_wave;
  logic              load, note_load, end_hit, playing;
  note_t             nw;

  assign nw        = note_t'(mem_data_i);
  assign playing   = (state_q == SQ_PLAY);
  assign mem_rd_o  = (state_q == SQ_ISSUE) || (playing && near_end);
  assign load      = vld_q && !stop_i && (state_q == SQ_WAIT || playing);
  assign note_load = load && !nw.fin;
  assign end_hit   = load && nw.fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      vld_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      vld_q <= mem_rd_o;
      irq_q <= end_hit;
      if (mem_rd_o) addr_q <= addr_q + ADDR_W'(1);
      if (stop_i) begin
        state_q <= SQ_IDLE;
      end else begin
        unique case (state_q)
          SQ_IDLE: if (start_i) begin
            state_q <= SQ_ISSUE;
            addr_q  <= base_addr_i;
          end
          SQ_ISSUE: state_q <= SQ_WAIT;
          default: begin
            if (end_hit)        state_q <= SQ_IDLE;
            else if (note_load) state_q <= SQ_PLAY;
          end
        endcase
      end
    end
  end

  melody_note_timer #(
    .LEN_W(LEN_W), .TEMPO_W(TEMPO_W), .TICK_SHIFT(TICK_SHIFT)
  ) i_timer (
    .clk_i, .rst_ni,
    .load_i(note_load), .clr_i(stop_i || end_hit),
    .len_i(nw.len), .tempo_i, .near_end_o(near_end)
  );

  melody_pitch_gen #(
    .PER_W(PER_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) i_pitch (
    .clk_i, .rst_ni,
    .load_i(note_load), .run_i(playing), .per_i(nw.per), .wave_o(wave)
  );

  melody_buzz_div #(.DIV_LOG2(BUZZ_LOG2)) i_buzz (
    .clk_i, .rst_ni, .wave_o(buzz_wave)
  );

  assign mem_addr_o = addr_q;
  assign irq_o      = irq_q;
  assign tone_o     = buzz_en_i ? buzz_wave : (playing && wave);
endmodule

// File: rtl/melody_tone_gen_chk.sv
module melody_tone_gen_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              buzz_en_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              tone_o,
  input logic              irq_o
);
  logic [2:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)); // R2
  AST_RD_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (buzz_en_i || !tone_o) && !mem_rd_o); // R7
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !irq_o && !mem_rd_o && (buzz_en_i || !tone_o)); // R8
  AST_BUZZ_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd5) && buzz_en_i && $past(buzz_en_i, 4) |-> tone_o != $past(tone_o, 4)); // R10
endmodule

bind melody_tone_gen melody_tone_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .buzz_en_i(buzz_en_i),
  .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .tone_o(tone_o), .irq_o(irq_o)
);

// File: tb/test_melody_tone_gen.sv
module test_melody_tone_gen;
  localparam int AW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start_i, stop_i, buzz_en_i;
  logic [3:0]    tempo_i;
  logic [AW-1:0] base_addr_i, mem_addr_o;
  logic          mem_rd_o, tone_o, irq_o;
  logic [12:0]   mem_data_i = '0;
  logic [12:0]   rom [256];

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R3";

  melody_tone_gen i_melody_tone_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .stop_i, .buzz_en_i, .tempo_i,
    .base_addr_i, .mem_rd_o, .mem_addr_o, .mem_data_i, .tone_o, .irq_o
  );

  always @(posedge clk) if (mem_rd_o) mem_data_i <= rom[mem_addr_o[7:0]];

  task automatic chk(input string tg, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tg, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_st, m_addr, m_left, m_ph, m_per, m_bc;
  bit m_irq;

  task automatic m_load(input logic [12:0] w);
    int len, t;
    if (w[12]) begin
      m_st = 0; m_irq = 1;
    end else begin
      m_per = int'(w[5:0]);
      if (m_per < 11) m_per = 11;
      if (m_per > 62) m_per = 62;
      len = (w[11:6] == 0) ? 1 : int'(w[11:6]);
      t = (tempo_i == 0) ? 1 : int'(tempo_i);
      m_left = len * (16 - t) * 256;
      m_ph = 0; m_st = 3;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_left = 0; m_ph = 0; m_per = 11; m_bc = 0; m_irq = 0;
    end else begin
      m_bc = (m_bc + 1) % 8;
      m_irq = 0;
      if (stop_i) m_st = 0;
      else case (m_st)
        0: if (start_i) begin m_st = 1; m_addr = int'(base_addr_i); end
        1: begin m_addr++; m_st = 2; end
        2: m_load(rom[(m_addr - 1) % 256]);
        default: begin
          if (m_left == 1) m_load(rom[(m_addr - 1) % 256]);
          else begin
            if (m_left == 2) m_addr++;
            m_left--;
            m_ph = (m_ph + 1) % m_per;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_tone, exp_rd;
      exp_tone = buzz_en_i ? int'(m_bc >= 4) : int'(m_st == 3 && m_ph < m_per - m_per / 2);
      exp_rd = int'(m_st == 1 || (m_st == 3 && m_left == 2));
      chk(buzz_en_i ? "R10" : tag, "tone", int'(tone_o), exp_tone);
      chk("R7", "irq", int'(irq_o), int'(m_irq));
      chk("R6", "read", int'(mem_rd_o), exp_rd);
      if (exp_rd == 1 && mem_rd_o) chk("R2", "addr", int'(mem_addr_o), m_addr % 4096);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 180000) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual %0d expected below %0d", cyc, 180000);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic play(input int base);
    base_addr_i = AW'(base);
    start_i = 1'b1; step(1); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    step(1);
    while (m_st != 0) step(1);
    step(4);
  endtask

  function automatic logic [12:0] nt(input bit fin, input int len, input int per);
    return {fin, 6'(len), 6'(per)};
  endfunction

  initial begin
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; buzz_en_i = 1'b0;
    tempo_i = 4'd15; base_addr_i = '0;
    for (int i = 0; i < 256; i++) rom[i] = nt(1, 0, 0);
    rom[8]  = nt(0, 1, 20); rom[9]  = nt(0, 2, 11); rom[10] = nt(0, 1, 62); rom[11] = nt(1, 0, 0);
    rom[32] = nt(0, 1, 3);  rom[33] = nt(0, 1, 63); rom[34] = nt(0, 0, 0);  rom[35] = nt(0, 1, 13);
    rom[36] = nt(1, 0, 0);
    rom[48] = nt(0, 1, 30); rom[49] = nt(1, 0, 0);

    repeat (3) @(negedge clk);
    chk("R1", "tone in reset", int'(tone_o), 0);
    chk("R1", "irq in reset", int'(irq_o), 0);
    chk("R1", "read in reset", int'(mem_rd_o), 0);
    step(1); rst_n = 1'b1;
    step(20);
    chk("R1", "idle read", int'(mem_rd_o), 0);

    tag = "R3"; tempo_i = 4'd15; play(8); wait_idle();
    tag = "R4"; tempo_i = 4'd14; play(32); wait_idle();
    tag = "R5"; tempo_i = 4'd0;  play(48); wait_idle();

    tag = "R8"; tempo_i = 4'd15; play(8); step(300);
    stop_i = 1'b1; step(1); stop_i = 1'b0; step(60);
    chk("R8", "idle after stop", int'(tone_o) + int'(mem_rd_o) + int'(irq_o), 0);

    tag = "R9"; play(8); step(100);
    base_addr_i = AW'(32); start_i = 1'b1; step(1); start_i = 1'b0;
    wait_idle();

    tag = "R10"; play(8); step(200);
    buzz_en_i = 1'b1; step(120); buzz_en_i = 1'b0;
    wait_idle();

    tag = "R3"; tempo_i = 4'd13; play(8); wait_idle();
    summary();
  end
endmodule